// File: doc/BRIEF.md
# Capture/Reload 16-bit Timer-Counter

This block is a 16-bit up counter paired with a 16-bit capture/reload register. An internal divider turns the core clock into a machine-cycle tick, one pulse every 12 clocks. Each tick either advances the counter directly (timer function) or samples a count pin and advances on a high-to-low pair of samples (counter function). A second pin serves either as an edge trigger or as the count direction.

Control inputs select one of four behaviours. With run low the block is off. With a baud select set it acts as a baud-rate generator. Otherwise the capture/reload select chooses between capture and auto-reload. Auto-reload either counts up or, with down-count enabled, counts up or down as the direction pin dictates. Software loads the counter and reload bytes, and clears the two flags, through a single byte-wide write port. The interrupt request is derived from the flags.

Top module: `tmr16_capreload`

## Requirements
- R1: After reset, the counter, the reload pair, both flags, the baud pulse and the interrupt request are all 0.
- R2: In timer function with run high, the counter advances by one once every 12 clocks. With run low the counter holds its value.
- R3: In counter function, the count pin is sampled on each machine-cycle tick. The counter advances by one only when one sample is 1 and the following sample is 0, so a static pin causes no counts.
- R4: In auto-reload with down-count disabled, a step from 0xFFFF loads the counter from the reload pair and sets the overflow flag.
- R5: In auto-reload with down-count disabled and external enable 1, a detected falling edge on the trigger pin loads the counter from the reload pair and sets the external flag. With external enable 0, such an edge changes nothing.
- R6: In capture mode (capture select 1, both baud selects 0), a trigger falling edge with external enable 1 copies the counter into the reload pair without disturbing the count, and sets the external flag. A step from 0xFFFF wraps the counter to 0x0000 and sets the overflow flag.
- R7: In auto-reload with down-count enabled, a trigger pin level of 1 counts up, and a step from 0xFFFF reloads the counter from the reload pair. A level of 0 counts down, and a step taken while the counter equals the reload pair loads 0xFFFF instead. Both events set the overflow flag.
- R8: With down-count enabled, each overflow or underflow toggles the external flag.
- R9: With either baud select set, a step from 0xFFFF reloads the counter and produces a one-clock baud pulse. The overflow flag stays clear, the capture select is ignored, and trigger edges have no effect.
- R10: The interrupt request equals the overflow flag OR'd with the external flag, and the external flag contributes only while down-count enable is 0.
- R11: Write port selects: 0 writes the counter low byte, 1 the counter high byte, 2 the reload low byte, 3 the reload high byte. Select 4 clears the overflow flag where data bit 0 is 1 and the external flag where data bit 1 is 1. A counter write takes effect over any count or reload in the same clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cnt_pin | input | 1 | External count input, synchronous to clk |
| trig_pin | input | 1 | Trigger edge input or count direction level |
| ctl_run | input | 1 | Run enable |
| ctl_ext_cnt | input | 1 | 1 selects counter function, 0 selects timer function |
| ctl_capture | input | 1 | 1 selects capture, 0 selects auto-reload |
| ctl_ext_en | input | 1 | Enables trigger-edge capture or reload |
| ctl_down_en | input | 1 | Enables up/down counting in auto-reload |
| ctl_rx_baud | input | 1 | Receive baud select |
| ctl_tx_baud | input | 1 | Transmit baud select |
| wr_en | input | 1 | Write strobe |
| wr_sel | input | 3 | Write target select |
| wr_data | input | 8 | Write data byte |
| ovf_flag | output | 1 | Overflow/underflow flag |
| ext_flag | output | 1 | External flag |
| baud_pulse | output | 1 | One-clock pulse on each baud-mode overflow |
| irq | output | 1 | Interrupt request |
| count_q | output | 16 | Counter value |
| reload_q | output | 16 | Capture/reload pair value |

## Verification
The underflow compare is the hardest case to reach from the ports. It needs down-count enabled, the direction pin held low, and a counter sitting a known small distance above the reload value, all while the free-running tick cannot be observed. The stimulus uses counter function with the count pin held idle, so the counter moves only on explicit pin pulses that each last two machine cycles. Software then loads the counter and reload values and steps down one pulse at a time through the equality point. The same pulse technique takes the trigger-edge reload, capture and baud overflow to exact, predictable counter values.

// File: rtl/tmr16_pkg.sv
package tmr16_pkg;

    localparam int CNT_W = 16;

    typedef enum logic [1:0] {
        MODE_OFF     = 2'd0,
        MODE_RELOAD  = 2'd1,
        MODE_CAPTURE = 2'd2,
        MODE_BAUD    = 2'd3
    } tmr_mode_e;

    typedef enum logic [2:0] {
        SEL_CNT_LO = 3'd0,
        SEL_CNT_HI = 3'd1,
        SEL_RLD_LO = 3'd2,
        SEL_RLD_HI = 3'd3,
        SEL_FLAGS  = 3'd4
    } wr_sel_e;

    typedef struct packed {
        logic [CNT_W-1:0] count;
        logic [CNT_W-1:0] reload;
        logic             ovf;
        logic             ext;
        logic             baud;
    } core_state_t;

    function automatic tmr_mode_e decode_mode(
        input logic run, input logic rx_b, input logic tx_b, input logic cap);
        if (!run)              return MODE_OFF;
        else if (rx_b || tx_b) return MODE_BAUD;
        else if (cap)          return MODE_CAPTURE;
        else                   return MODE_RELOAD;
    endfunction

endpackage

// File: rtl/tmr16_mcyc.sv
module tmr16_mcyc #(
    parameter int DIV = 12
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int DW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [DW-1:0] LAST = DW'(DIV - 1);

    logic [DW-1:0] div_d, div_q;

    always_comb begin
        div_d = (div_q == LAST) ? '0 : div_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) div_q <= '0;
        else        div_q <= div_d;
    end

    assign tick = (div_q == LAST);
endmodule

// File: rtl/tmr16_fall.sv
module tmr16_fall (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic pin,
    output logic fall
);
    logic samp_d, samp_q;

    always_comb begin
        samp_d = tick ? pin : samp_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) samp_q <= 1'b0;
        else        samp_q <= samp_d;
    end

    // previous sample high, current sample low
    assign fall = tick & samp_q & ~pin;
endmodule

// File: rtl/tmr16_capreload.sv
module tmr16_capreload
    import tmr16_pkg::*;
#(
    parameter int DIV = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cnt_pin,
    input  logic             trig_pin,
    input  logic             ctl_run,
    input  logic             ctl_ext_cnt,
    input  logic             ctl_capture,
    input  logic             ctl_ext_en,
    input  logic             ctl_down_en,
    input  logic             ctl_rx_baud,
    input  logic             ctl_tx_baud,
    input  logic             wr_en,
    input  logic [2:0]       wr_sel,
    input  logic [7:0]       wr_data,
    output logic             ovf_flag,
    output logic             ext_flag,
    output logic             baud_pulse,
    output logic             irq,
    output logic [CNT_W-1:0] count_q,
    output logic [CNT_W-1:0] reload_q
);
    localparam int NPIN = 2;
    localparam int HI_W = CNT_W - 8;

    logic            tick;
    logic [NPIN-1:0] pins, falls;
    core_state_t     st_d, st_q;
    tmr_mode_e       mode;
    logic            step, dir_up, trig_act, updown;

    tmr16_mcyc #(.DIV(DIV)) u_mcyc (.clk(clk), .rst_n(rst_n), .tick(tick));

    assign pins = {trig_pin, cnt_pin};

    for (genvar g = 0; g < NPIN; g++) begin : g_fall
        tmr16_fall u_fall (
            .clk(clk), .rst_n(rst_n), .tick(tick), .pin(pins[g]), .fall(falls[g])
        );
    end

    always_comb begin
        mode     = decode_mode(ctl_run, ctl_rx_baud, ctl_tx_baud, ctl_capture);
        updown   = (mode == MODE_RELOAD) && ctl_down_en;
        step     = (mode != MODE_OFF) && (ctl_ext_cnt ? falls[0] : tick);
        dir_up   = !updown || trig_pin;
        trig_act = falls[1] && ctl_ext_en &&
                   ((mode == MODE_CAPTURE) || ((mode == MODE_RELOAD) && !ctl_down_en));

        st_d      = st_q;
        st_d.baud = 1'b0;

        // software clears first so that hardware sets win
        if (wr_en && wr_sel == SEL_FLAGS) begin
            st_d.ovf = st_q.ovf & ~wr_data[0];
            st_d.ext = st_q.ext & ~wr_data[1];
        end

        if (step) begin
            if (dir_up) begin
                if (st_q.count == '1) begin
                    st_d.count = (mode == MODE_CAPTURE) ? '0 : st_q.reload;
                    if (mode == MODE_BAUD) st_d.baud = 1'b1;
                    else                   st_d.ovf  = 1'b1;
                    if (updown)            st_d.ext  = ~st_q.ext;
                end else begin
                    st_d.count = st_q.count + 1'b1;
                end
            end else begin
                if (st_q.count == st_q.reload) begin
                    st_d.count = '1;
                    st_d.ovf   = 1'b1;
                    st_d.ext   = ~st_q.ext;
                end else begin
                    st_d.count = st_q.count - 1'b1;
                end
            end
        end

        if (trig_act) begin
            st_d.ext = 1'b1;
            if (mode == MODE_CAPTURE) st_d.reload = st_q.count;
            else                      st_d.count  = st_q.reload;
        end

        if (wr_en) begin
            case (wr_sel)
                SEL_CNT_LO: st_d.count[7:0]        = wr_data;
                SEL_CNT_HI: st_d.count[CNT_W-1:8]  = wr_data[HI_W-1:0];
                SEL_RLD_LO: st_d.reload[7:0]       = wr_data;
                SEL_RLD_HI: st_d.reload[CNT_W-1:8] = wr_data[HI_W-1:0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign count_q    = st_q.count;
    assign reload_q   = st_q.reload;
    assign ovf_flag   = st_q.ovf;
    assign ext_flag   = st_q.ext;
    assign baud_pulse = st_q.baud;
    assign irq        = st_q.ovf | (st_q.ext & ~ctl_down_en);
endmodule

// File: rtl/tmr16_chk.sv
module tmr16_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        ctl_run,
    input logic        ctl_ext_en,
    input logic        ctl_down_en,
    input logic        ctl_rx_baud,
    input logic        ctl_tx_baud,
    input logic        wr_en,
    input logic [2:0]  wr_sel,
    input logic [7:0]  wr_data,
    input logic        ovf_flag,
    input logic        ext_flag,
    input logic        baud_pulse,
    input logic [15:0] count_q
);
    AST_OFF_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl_run && !wr_en) |=> $stable(count_q)); // R2

    AST_OVF_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf_flag) |-> $past(ctl_run)); // R4

    AST_EXT_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(ext_flag) && !$past(ctl_down_en)) |-> $past(ctl_ext_en)); // R5

    AST_BAUD_NO_OVF: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_run && (ctl_rx_baud || ctl_tx_baud) && !ovf_flag) |=> !ovf_flag); // R9

    AST_BAUD_ONLY_IN_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(baud_pulse) |-> $past(ctl_run && (ctl_rx_baud || ctl_tx_baud))); // R9

    AST_CNT_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == 3'd0) |=> (count_q[7:0] == $past(wr_data))); // R11
endmodule

bind tmr16_capreload tmr16_chk u_chk (
    .clk(clk), .rst_n(rst_n), .ctl_run(ctl_run), .ctl_ext_en(ctl_ext_en),
    .ctl_down_en(ctl_down_en), .ctl_rx_baud(ctl_rx_baud), .ctl_tx_baud(ctl_tx_baud),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data), .ovf_flag(ovf_flag),
    .ext_flag(ext_flag), .baud_pulse(baud_pulse), .count_q(count_q)
);

// File: tb/tmr16_capreload_tb.sv
module tmr16_capreload_tb;
    localparam int CLK_PERIOD = 10;
    localparam int HOLD = 30;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cnt_pin = 1'b1, trig_pin = 1'b1;
    logic ctl_run = 0, ctl_ext_cnt = 0, ctl_capture = 0, ctl_ext_en = 0;
    logic ctl_down_en = 0, ctl_rx_baud = 0, ctl_tx_baud = 0;
    logic wr_en = 0;
    logic [2:0] wr_sel = '0;
    logic [7:0] wr_data = '0;
    logic ovf_flag, ext_flag, baud_pulse, irq;
    logic [15:0] count_q, reload_q;

    int checks = 0, failures = 0, baud_cnt = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tmr16_capreload u_dut (
        .clk(clk), .rst_n(rst_n), .cnt_pin(cnt_pin), .trig_pin(trig_pin),
        .ctl_run(ctl_run), .ctl_ext_cnt(ctl_ext_cnt), .ctl_capture(ctl_capture),
        .ctl_ext_en(ctl_ext_en), .ctl_down_en(ctl_down_en), .ctl_rx_baud(ctl_rx_baud),
        .ctl_tx_baud(ctl_tx_baud), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .ovf_flag(ovf_flag), .ext_flag(ext_flag), .baud_pulse(baud_pulse), .irq(irq),
        .count_q(count_q), .reload_q(reload_q)
    );

    always @(negedge clk) if (rst_n && baud_pulse) baud_cnt++;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] sel, input logic [7:0] data);
        wr_en = 1; wr_sel = sel; wr_data = data;
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic load(input logic [15:0] cnt, input logic [15:0] rld);
        wr(3'd0, cnt[7:0]); wr(3'd1, cnt[15:8]);
        wr(3'd2, rld[7:0]); wr(3'd3, rld[15:8]);
    endtask

    task automatic idle_ctl();
        ctl_run = 0; ctl_ext_cnt = 0; ctl_capture = 0; ctl_ext_en = 0;
        ctl_down_en = 0; ctl_rx_baud = 0; ctl_tx_baud = 0;
        cnt_pin = 1; trig_pin = 1;
        repeat (HOLD) @(negedge clk);
        wr(3'd4, 8'h03);
    endtask

    task automatic cnt_pulse();
        cnt_pin = 0; repeat (HOLD) @(negedge clk);
        cnt_pin = 1; repeat (HOLD) @(negedge clk);
    endtask

    task automatic trig_pulse();
        trig_pin = 0; repeat (HOLD) @(negedge clk);
        trig_pin = 1; repeat (HOLD) @(negedge clk);
    endtask

    task automatic t_reset();
        check("R1 count", count_q, 0);
        check("R1 reload", reload_q, 0);
        check("R1 flags", {ovf_flag, ext_flag, baud_pulse, irq}, 0);
    endtask

    task automatic t_timer();
        logic [15:0] prev;
        int n;
        idle_ctl();
        load(16'h0040, 16'h0000);
        repeat (50) @(negedge clk);
        check("R2 off holds", count_q, 16'h0040);
        ctl_run = 1;
        prev = count_q; n = 0;
        while (count_q == prev && n < 40) begin @(negedge clk); n++; end
        prev = count_q; n = 0;
        while (count_q == prev && n < 40) begin @(negedge clk); n++; end
        check("R2 tick interval", n, 12);
        check("R2 step of one", count_q, prev + 16'd1);
        ctl_run = 0;
    endtask

    task automatic t_counter();
        idle_ctl();
        ctl_ext_cnt = 1;
        load(16'h0100, 16'h0000);
        ctl_run = 1;
        repeat (100) @(negedge clk);
        check("R3 static pin no count", count_q, 16'h0100);
        for (int i = 0; i < 3; i++) cnt_pulse();
        check("R3 three falls", count_q, 16'h0103);
    endtask

    task automatic t_reload_up();
        idle_ctl();
        ctl_ext_cnt = 1;
        load(16'hFFFE, 16'h1234);
        ctl_run = 1;
        cnt_pulse();
        check("R4 before top", {ovf_flag, count_q}, {1'b0, 16'hFFFF});
        cnt_pulse();
        check("R4 reload on overflow", count_q, 16'h1234);
        check("R4 ovf set", ovf_flag, 1);
        check("R10 irq from ovf", irq, 1);
    endtask

    task automatic t_trig_reload();
        idle_ctl();
        ctl_ext_cnt = 1;
        load(16'h0100, 16'h5555);
        ctl_run = 1;
        trig_pulse();
        check("R5 ext_en=0 ignored", {ext_flag, count_q}, {1'b0, 16'h0100});
        ctl_ext_en = 1;
        trig_pulse();
        check("R5 trigger reload", count_q, 16'h5555);
        check("R5 ext set", ext_flag, 1);
    endtask

    task automatic t_capture();
        idle_ctl();
        ctl_ext_cnt = 1; ctl_capture = 1; ctl_ext_en = 1;
        load(16'hABCD, 16'h0000);
        ctl_run = 1;
        trig_pulse();
        check("R6 captured", reload_q, 16'hABCD);
        check("R6 count kept", count_q, 16'hABCD);
        check("R6 ext set", ext_flag, 1);
        check("R10 irq from ext", irq, 1);
        load(16'hFFFF, 16'hABCD);
        cnt_pulse();
        check("R6 wrap to zero", count_q, 16'h0000);
        check("R6 ovf set", ovf_flag, 1);
        wr(3'd4, 8'h01);
        check("R11 clear ovf only", {ovf_flag, ext_flag}, 2'b01);
        wr(3'd4, 8'h02);
        check("R11 clear ext", {ovf_flag, ext_flag}, 2'b00);
    endtask

    task automatic t_updown();
        idle_ctl();
        ctl_ext_cnt = 1; ctl_down_en = 1; ctl_ext_en = 1;
        trig_pin = 0;
        repeat (HOLD) @(negedge clk);
        load(16'h0012, 16'h0010);
        ctl_run = 1;
        cnt_pulse();
        check("R7 down one", count_q, 16'h0011);
        cnt_pulse();
        check("R7 at reload no flag", {ovf_flag, count_q}, {1'b0, 16'h0010});
        cnt_pulse();
        check("R7 underflow loads ffff", count_q, 16'hFFFF);
        check("R7 underflow ovf", ovf_flag, 1);
        check("R8 ext toggled on", ext_flag, 1);
        wr(3'd4, 8'h01);
        check("R10 ext masked when down_en", irq, 0);
        trig_pin = 1;
        repeat (HOLD) @(negedge clk);
        cnt_pulse();
        check("R7 up overflow reloads", count_q, 16'h0010);
        check("R8 ext toggled off", ext_flag, 0);
        check("R7 overflow ovf", ovf_flag, 1);
    endtask

    task automatic t_baud();
        int b0;
        idle_ctl();
        ctl_ext_cnt = 1; ctl_rx_baud = 1; ctl_capture = 1; ctl_ext_en = 1;
        load(16'hFFFE, 16'h8000);
        ctl_run = 1;
        b0 = baud_cnt;
        cnt_pulse();
        cnt_pulse();
        check("R9 baud reload", count_q, 16'h8000);
        check("R9 one baud pulse", baud_cnt - b0, 1);
        check("R9 no ovf", ovf_flag, 0);
        trig_pulse();
        check("R9 trigger ignored", {ext_flag, reload_q, count_q}, {1'b0, 16'h8000, 16'h8000});
    endtask

    task automatic t_write_prio();
        idle_ctl();
        load(16'h0000, 16'h0000);
        ctl_run = 1;
        for (int i = 0; i < 30; i++) begin
            wr(3'd0, 8'(i + 1));
            check("R11 counter write wins", count_q, 16'(i + 1));
        end
        ctl_run = 0;
        wr(3'd3, 8'hC3);
        check("R11 reload high byte", reload_q, 16'hC300);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_timer();
        t_counter();
        t_reload_up();
        t_trig_reload();
        t_capture();
        t_updown();
        t_baud();
        t_write_prio();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule